// File: doc/BRIEF.md
# Address-Masked GPIO Data Register

This block holds the output data of an eight-pin general-purpose I/O port and serves its read path. It sits behind a 256-word address window. Address bits [9:2] act as a per-pin access mask, so every access touches only the pins chosen by the address used. Software can therefore set or sample a single pin, or any subset of pins, with one bus access. It does not need a read-modify-write sequence.

On a write, the block stores the masked data bits at the clock edge of the write strobe. It drives the stored values towards the pads, but only on pins whose direction input marks them as outputs. On a read, each selected pin returns its stored value if it is an output, or its live pad level if it is an input. Unselected pins read as zero. The read result is registered and appears one cycle after the read strobe. A two-state phase machine controls it. `RD_IDLE` means no result is presented and the read bus is zero. `RD_PRESENT` means a captured result is on the bus. The transition `IDLE→PRESENT` or `PRESENT→PRESENT` is taken on any cycle with the read strobe. The transition `→IDLE` is taken on any cycle without it.

Top module: `gpio_amask_data`

## Requirements
- R1: After a synchronous reset, all stored data bits are 0, `pad_out` is 0 and `rd_data` is 0.
- R2: A write updates stored bit n to `bus_wdata[n]` only where `bus_addr[n+2]` is 1. All other stored bits keep their value. The new value is visible from the clock edge that samples `wr_stb`.
- R3: In a read result, every pin bit n with `bus_addr[n+2]` = 0 reads 0, and `rd_data` bits above the pin count are always 0.
- R4: For a selected pin, a read returns the stored bit when `pin_dir[n]` = 1 (output). It returns `pad_in[n]` when `pin_dir[n]` = 0 (input).
- R5: `pad_out[n]` equals the stored bit when `pin_dir[n]` = 1 and is 0 otherwise. A value written while a pin is an input appears on `pad_out` once the pin turns to output.
- R6: The byte offset 1 << (n+2) from the window base selects pin n alone, for both writes and reads.
- R7: `bus_addr[1:0]` has no effect on any access.
- R8: `rd_data` carries the result of a read in the cycle after `rd_stb` and is 0 in any cycle not preceded by a read strobe. Back-to-back reads give back-to-back results.
- R9: When `wr_stb` and `rd_stb` are high in the same cycle, the write is applied and the read returns the values stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | NPINS+2 | Byte address within the window; bits [NPINS+1:2] are the pin mask |
| bus_wdata | input | DATA_W | Write data; low NPINS bits are used |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| pin_dir | input | NPINS | Per-pin direction, 1 = output |
| pad_in | input | NPINS | Synchronized pad levels |
| pad_out | output | NPINS | Output data towards the pads, gated by direction |
| rd_data | output | DATA_W | Registered read result |

## Verification
The bench builds the block with its defaults: eight pins and a 32-bit data bus, so the address is ten bits wide. With these values the whole 256-word window can be reached. That covers every single-pin offset, the all-pins address, partial masks, and addresses with the two low bits set. The zero padding of the read bus above the pins is also exercised. Mixed direction patterns against chosen pad levels show the choice between stored value and pad level on each pin.

// File: rtl/gpio_amask_pkg.sv
package gpio_amask_pkg;

    typedef enum logic [0:0] {
        RD_IDLE    = 1'b0,
        RD_PRESENT = 1'b1
    } rd_phase_e;

    localparam int unsigned MASK_LSB = 2;

endpackage

// File: rtl/gam_mask_decode.sv
module gam_mask_decode #(
    parameter int unsigned NPINS = 8
) (
    input  logic [NPINS+1:0] addr,
    output logic [NPINS-1:0] mask
);
    import gpio_amask_pkg::*;

    localparam int unsigned MSB = NPINS + MASK_LSB - 1;

    // word offset bits form the pin mask; byte lane bits are dropped
    assign mask = addr[MSB:MASK_LSB];

    logic [MASK_LSB-1:0] unused_lane;
    assign unused_lane = addr[MASK_LSB-1:0];

endmodule

// File: rtl/gam_out_bank.sv
module gam_out_bank #(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [NPINS-1:0] mask,
    input  logic [NPINS-1:0] wdata,
    input  logic [NPINS-1:0] dir,
    output logic [NPINS-1:0] data_q,
    output logic [NPINS-1:0] pad_out
);

    for (genvar n = 0; n < NPINS; n++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[n] <= 1'b0;
            end else if (wr_en && mask[n]) begin
                data_q[n] <= wdata[n];
            end
        end

        assign pad_out[n] = dir[n] & data_q[n];
    end

endmodule

// File: rtl/gam_read_sel.sv
module gam_read_sel #(
    parameter int unsigned NPINS = 8
) (
    input  logic [NPINS-1:0] mask,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] data_q,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] rsel
);

    for (genvar n = 0; n < NPINS; n++) begin : g_bit
        logic src;
        assign src     = dir[n] ? data_q[n] : pad_in[n];
        assign rsel[n] = mask[n] & src;
    end

endmodule

// File: rtl/gpio_amask_data.sv
module gpio_amask_data #(
    parameter int unsigned NPINS  = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NPINS+1:0]    bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                wr_stb,
    input  logic                rd_stb,
    input  logic [NPINS-1:0]    pin_dir,
    input  logic [NPINS-1:0]    pad_in,
    output logic [NPINS-1:0]    pad_out,
    output logic [DATA_W-1:0]   rd_data
);
    import gpio_amask_pkg::*;

    localparam int unsigned PAD_W = DATA_W - NPINS;

    logic [NPINS-1:0] mask;
    logic [NPINS-1:0] data_q;
    logic [NPINS-1:0] rsel;
    logic [NPINS-1:0] snap_q;
    rd_phase_e        phase_q;
    rd_phase_e        phase_d;

    logic [PAD_W-1:0] unused_wdata_hi;
    assign unused_wdata_hi = bus_wdata[DATA_W-1:NPINS];

    gam_mask_decode #(.NPINS(NPINS)) u_dec (
        .addr (bus_addr),
        .mask (mask)
    );

    gam_out_bank #(.NPINS(NPINS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_stb),
        .mask    (mask),
        .wdata   (bus_wdata[NPINS-1:0]),
        .dir     (pin_dir),
        .data_q  (data_q),
        .pad_out (pad_out)
    );

    gam_read_sel #(.NPINS(NPINS)) u_rsel (
        .mask   (mask),
        .dir    (pin_dir),
        .data_q (data_q),
        .pad_in (pad_in),
        .rsel   (rsel)
    );

    // next phase
    always_comb begin
        phase_d = RD_IDLE;
        unique case (phase_q)
            RD_IDLE:    phase_d = rd_stb ? RD_PRESENT : RD_IDLE;
            RD_PRESENT: phase_d = rd_stb ? RD_PRESENT : RD_IDLE;
        endcase
    end

    // state register and read capture
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= RD_IDLE;
            snap_q  <= '0;
        end else begin
            phase_q <= phase_d;
            if (rd_stb) begin
                snap_q <= rsel;
            end
        end
    end

    // outputs
    always_comb begin
        rd_data = '0;
        unique case (phase_q)
            RD_IDLE:    rd_data = '0;
            RD_PRESENT: rd_data = {{PAD_W{1'b0}}, snap_q};
        endcase
    end

endmodule

// File: rtl/gpio_amask_data_chk.sv
module gpio_amask_data_chk #(
    parameter int unsigned NPINS  = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [NPINS+1:0]  bus_addr,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic [NPINS-1:0]  pin_dir,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  data_q,
    input logic [DATA_W-1:0] rd_data
);
    logic [NPINS-1:0] amask;
    assign amask = bus_addr[NPINS+1:2];

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_stb) |-> rd_data == '0);

    assert_masked_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> ((data_q ^ $past(data_q)) & ~$past(amask)) == '0);

    assert_no_write_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(data_q));

    assert_unselected_zero_R3: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> (rd_data[NPINS-1:0] & ~$past(amask)) == '0
                   && rd_data[DATA_W-1:NPINS] == '0);

    assert_output_readback_R4: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> (rd_data[NPINS-1:0] & $past(amask & pin_dir))
                   == $past(data_q & amask & pin_dir));

    assert_drive_gated_R5: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pin_dir) == '0);

endmodule

bind gpio_amask_data gpio_amask_data_chk #(.NPINS(NPINS), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .pin_dir  (pin_dir),
    .pad_out  (pad_out),
    .data_q   (data_q),
    .rd_data  (rd_data)
);

// File: tb/sim_gpio_amask_data.sv
module sim_gpio_amask_data;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        wr_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic [7:0]  pin_dir = 8'hFF;
    logic [7:0]  pad_in = 8'h00;
    logic [7:0]  pad_out;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    logic [7:0]  model = 8'h00;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    gpio_amask_data u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .pin_dir(pin_dir), .pad_in(pad_in),
        .pad_out(pad_out), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_rd(input logic [9:0] a);
        logic [7:0] m = a[9:2];
        return {24'h0, ((pin_dir & model) | (~pin_dir & pad_in)) & m};
    endfunction

    // driver tasks: called at a negedge, hold strobes for one cycle
    task automatic do_write(input logic [9:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = {24'hA5A5A5, d}; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        model = (model & ~a[9:2]) | (d & a[9:2]);
    endtask

    task automatic do_read(input logic [9:0] a, input string req);
        bus_addr = a; rd_stb = 1'b1;
        exp_q.push_back(expect_rd(a));
        tag_q.push_back(req);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic do_both(input logic [9:0] a, input logic [7:0] d, input string req);
        bus_addr = a; bus_wdata = {24'h0, d}; wr_stb = 1'b1; rd_stb = 1'b1;
        exp_q.push_back(expect_rd(a));
        tag_q.push_back(req);
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
        model = (model & ~a[9:2]) | (d & a[9:2]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: pops one expected item per read, checks zero otherwise
    initial begin
        logic seen;
        forever begin
            @(posedge clk);
            seen = rd_stb;
            @(negedge clk);
            if (mon_on) begin
                if (seen) begin
                    if (exp_q.size() == 0) check("R8 unexpected", rd_data, 32'hX);
                    else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
                end else begin
                    check("R8 idle", rd_data, 32'h0);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pad_out", {24'h0, pad_out}, 32'h0);
        check("R1 rd_data", rd_data, 32'h0);
        mon_on = 1'b1;
        do_read(10'h3FC, "R1 readback");

        do_write(10'h3FC, 8'hFF);
        check("R2 pad_out all", {24'h0, pad_out}, {24'h0, model});
        do_read(10'h3FC, "R2 all pins");

        do_write(10'h1 << 5, 8'h00);           // pin 3 alone
        do_read(10'h3FC, "R6 single clear");
        do_write(10'h0F << 2, 8'hF0);          // low nibble masked, data ignored high
        do_read(10'h3FC, "R2 partial mask");
        do_read(10'h30 << 2, "R3 mask 30");
        do_read(10'h1 << 9, "R6 pin 7 read");
        do_read(10'h1 << 2, "R6 pin 0 read");

        do_write(10'h3FF, 8'h5A);              // low address bits set
        do_read(10'h3FC, "R7 write lanes");
        do_read(10'h3FD, "R7 read lane1");
        do_read(10'h3FE, "R7 read lane2");

        pin_dir = 8'h0F; pad_in = 8'hA5;
        @(negedge clk);
        check("R5 gated", {24'h0, pad_out}, {24'h0, model & 8'h0F});
        do_read(10'h3FC, "R4 mixed dir");
        pad_in = 8'h3C;
        do_read(10'h3FC, "R4 live pad");
        do_read(10'hF0 << 2, "R4 input only");

        do_write(10'hF0 << 2, 8'h90);          // write to input pins
        check("R5 inputs undriven", {24'h0, pad_out}, {24'h0, model & 8'h0F});
        pin_dir = 8'hFF;
        @(negedge clk);
        check("R5 turn output", {24'h0, pad_out}, {24'h0, model});

        do_both(10'h3FC, 8'h33, "R9 pre-write");
        do_read(10'h3FC, "R9 post-write");
        do_read(10'h3FC, "R8 back-to-back");
        idle(3);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; model = 8'h00;
        @(negedge clk);
        check("R1 second reset", {24'h0, pad_out}, 32'h0);
        do_read(10'h3FC, "R1 after reset");
        idle(2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule